// File: doc/BRIEF.md
# I2C Byte FIFO Buffer with Threshold Flags

This block sits between a processor register port and an I2C shift engine and holds one byte queue per direction. The processor writes outgoing bytes into the transmit queue, which the shift engine pops one at a time. The shift engine pushes incoming bytes into the receive queue, which the processor reads. A single 16-bit configuration word sets a threshold for each direction, holds the two DMA enable bits, and carries a flush bit per queue that clears itself.

Ready flags tell the processor when a full threshold group can be moved in one burst. Drain flags tell it when the transfer is nearly done and only a final group smaller than the threshold remains. The `remainCnt` input gives the number of transfer bytes the processor has not yet moved. A status word reports the queue depth code, the receive fill level and the free room in the transmit queue. That room is the exact count the processor uses when it services a drain flag. A push into a full receive queue and a pop from an empty transmit queue are reported as one-cycle event pulses.

Top module: `i2c_thresh_fifo`

## Requirements
- R1: The configuration word reads back as written, with these fields: bit 15 receive DMA enable, bits [13:8] receive threshold minus one, bit 7 transmit DMA enable, bits [5:0] transmit threshold minus one. The flush bits 14 (receive) and 6 (transmit) always read 0. `rxDmaEn` and `txDmaEn` follow bits 15 and 7.
- R2: Each queue is first-in first-out. `engTxData` shows the oldest transmit byte and `cpuRxData` shows the oldest receive byte, whenever the queue holds data.
- R3: The status word holds the depth code in bits [15:14], where depth = 8 << code. Bits [13:8] hold the receive fill level, bits [5:0] hold the free transmit room, and bits [7:6] are 0.
- R4: `rxReady` is 1 exactly when the receive fill level is at least the receive threshold (field + 1).
- R5: `txReady` is 1 exactly when the free transmit room is at least the transmit threshold (field + 1).
- R6: `rxDrain` is 1 exactly when 0 < `remainCnt` < receive threshold and the receive fill level is at least `remainCnt`.
- R7: `txDrain` is 1 exactly when 0 < `remainCnt` < transmit threshold and the free transmit room is at least `remainCnt`.
- R8: Writing the configuration word with bit 14 (or bit 6) set empties the receive (or transmit) queue at the following clock edge. Pushes and pops in that cycle are discarded, and the other queue is unaffected.
- R9: An engine push while the receive queue is full drops the byte, leaves the queue unchanged and raises `rxOverrun` for exactly the next cycle.
- R10: An engine pop while the transmit queue is empty leaves the queue unchanged and raises `txUnderflow` for exactly the next cycle.
- R11: A processor write to a full transmit queue or a read of an empty receive queue has no effect on either queue.
- R12: After reset both queues are empty, the configuration word is 0 (thresholds of 1) and no event pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration word write strobe |
| cfgWrData | input | 16 | Configuration word write value |
| cfgRdData | output | 16 | Configuration word read value |
| statRdData | output | 16 | Status word (depth code, levels) |
| rxDmaEn | output | 1 | Receive DMA enable bit |
| txDmaEn | output | 1 | Transmit DMA enable bit |
| cpuTxWr | input | 1 | Processor writes a transmit byte |
| cpuTxData | input | 8 | Transmit byte from processor |
| cpuRxRd | input | 1 | Processor reads a receive byte |
| cpuRxData | output | 8 | Oldest receive byte |
| engTxPop | input | 1 | Shift engine takes a transmit byte |
| engTxData | output | 8 | Oldest transmit byte |
| engRxPush | input | 1 | Shift engine delivers a receive byte |
| engRxData | input | 8 | Receive byte from shift engine |
| remainCnt | input | CNT_W | Transfer bytes not yet moved by the processor |
| txReady | output | 1 | Room for a transmit threshold group |
| rxReady | output | 1 | A receive threshold group is available |
| txDrain | output | 1 | Final short transmit group can be written |
| rxDrain | output | 1 | Final short receive group is available |
| txUnderflow | output | 1 | One-cycle pulse: pop from empty transmit queue |
| rxOverrun | output | 1 | One-cycle pulse: push to full receive queue |

## Verification
The assertions assume that the handshake inputs can arrive in any combination, including a push onto a full queue, a pop from an empty one, and a push and a pop together at the limits. They also assume that a configuration write can land in the same cycle as queue traffic. The only assumption they make about inputs is that they are stable around the clock edge. The stimulus drives all inputs on the falling edge. It walks each queue past full and past empty on purpose, and it issues flushes while bytes are moving. It then runs a long random phase with frequent threshold rewrites and `remainCnt` values that straddle the thresholds.

// File: rtl/i2cfb_pkg.sv
package i2cfb_pkg;
  // configuration word bit positions
  localparam int CFG_RX_DMA   = 15;
  localparam int CFG_RX_FLUSH = 14;
  localparam int CFG_RX_TH    = 8;
  localparam int CFG_TX_DMA   = 7;
  localparam int CFG_TX_FLUSH = 6;
  localparam int CFG_TX_TH    = 0;
  localparam int TH_W         = 6;
  localparam int FIELD_W      = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxPop;
    logic rxFlush;
  } fifoStrobes_t;
endpackage

// File: rtl/i2cfb_fifo.sv
module i2cfb_fifo #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int LVW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [LVW-1:0]    level
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr;
  logic [AW-1:0]     rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
      level <= level + LVW'(push) - LVW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];
endmodule

// File: rtl/i2cfb_datapath.sv
module i2cfb_datapath
  import i2cfb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rstN,
  input  fifoStrobes_t strobes,
  input  logic [7:0]   cpuTxData,
  input  logic [7:0]   engRxData,
  output logic [7:0]   engTxData,
  output logic [7:0]   cpuRxData,
  output logic [LVW-1:0] txLevel,
  output logic [LVW-1:0] rxLevel
);
  i2cfb_fifo #(.DEPTH(DEPTH), .DATA_W(8), .LVW(LVW)) u_txFifo (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobes.txPush),
    .pop    (strobes.txPop),
    .flush  (strobes.txFlush),
    .wrData (cpuTxData),
    .rdData (engTxData),
    .level  (txLevel)
  );

  i2cfb_fifo #(.DEPTH(DEPTH), .DATA_W(8), .LVW(LVW)) u_rxFifo (
    .clk    (clk),
    .rstN   (rstN),
    .push   (strobes.rxPush),
    .pop    (strobes.rxPop),
    .flush  (strobes.rxFlush),
    .wrData (engRxData),
    .rdData (cpuRxData),
    .level  (rxLevel)
  );
endmodule

// File: rtl/i2cfb_ctrl.sv
module i2cfb_ctrl
  import i2cfb_pkg::*;
#(
  parameter int DEPTH_CODE = 1,
  parameter int DEPTH      = 8 << DEPTH_CODE,
  parameter int LVW        = $clog2(DEPTH + 1),
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [15:0]      cfgWrData,
  output logic [15:0]      cfgRdData,
  output logic [15:0]      statRdData,
  output logic             rxDmaEn,
  output logic             txDmaEn,
  input  logic             cpuTxWr,
  input  logic             cpuRxRd,
  input  logic             engTxPop,
  input  logic             engRxPush,
  input  logic [CNT_W-1:0] remainCnt,
  input  logic [LVW-1:0]   txLevel,
  input  logic [LVW-1:0]   rxLevel,
  output fifoStrobes_t     strobes,
  output logic             txReady,
  output logic             rxReady,
  output logic             txDrain,
  output logic             rxDrain,
  output logic             txUnderflow,
  output logic             rxOverrun
);
  localparam int CMPW = (CNT_W > 8) ? CNT_W : 8;

  logic [TH_W-1:0] rxThField, txThField;
  logic            rxFlushQ, txFlushQ;
  logic            rxFull, txEmpty;
  logic [LVW-1:0]  txFree;
  logic [CMPW-1:0] rxThr, txThr, rxLvlW, txFreeW, remW;
  logic            remNonZero;

  // configuration register; flush bits live for one cycle only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxDmaEn   <= 1'b0;
      txDmaEn   <= 1'b0;
      rxThField <= '0;
      txThField <= '0;
      rxFlushQ  <= 1'b0;
      txFlushQ  <= 1'b0;
    end else begin
      rxFlushQ <= cfgWrEn && cfgWrData[CFG_RX_FLUSH];
      txFlushQ <= cfgWrEn && cfgWrData[CFG_TX_FLUSH];
      if (cfgWrEn) begin
        rxDmaEn   <= cfgWrData[CFG_RX_DMA];
        txDmaEn   <= cfgWrData[CFG_TX_DMA];
        rxThField <= cfgWrData[CFG_RX_TH +: TH_W];
        txThField <= cfgWrData[CFG_TX_TH +: TH_W];
      end
    end
  end

  assign cfgRdData = {rxDmaEn, 1'b0, rxThField, txDmaEn, 1'b0, txThField};

  // handshake qualification
  assign rxFull  = (rxLevel == LVW'(DEPTH));
  assign txEmpty = (txLevel == '0);
  assign txFree  = LVW'(DEPTH) - txLevel;

  always_comb begin
    strobes.rxFlush = rxFlushQ;
    strobes.txFlush = txFlushQ;
    strobes.rxPush  = engRxPush && !rxFull && !rxFlushQ;
    strobes.rxPop   = cpuRxRd && (rxLevel != '0) && !rxFlushQ;
    strobes.txPush  = cpuTxWr && (txLevel != LVW'(DEPTH)) && !txFlushQ;
    strobes.txPop   = engTxPop && !txEmpty && !txFlushQ;
  end

  // error events, one-cycle pulses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxOverrun   <= 1'b0;
      txUnderflow <= 1'b0;
    end else begin
      rxOverrun   <= engRxPush && rxFull && !rxFlushQ;
      txUnderflow <= engTxPop && txEmpty && !txFlushQ;
    end
  end

  // threshold and drain comparisons
  assign rxThr      = CMPW'(rxThField) + CMPW'(1);
  assign txThr      = CMPW'(txThField) + CMPW'(1);
  assign rxLvlW     = CMPW'(rxLevel);
  assign txFreeW    = CMPW'(txFree);
  assign remW       = CMPW'(remainCnt);
  assign remNonZero = (remainCnt != '0);

  assign rxReady = (rxLvlW >= rxThr);
  assign txReady = (txFreeW >= txThr);
  assign rxDrain = remNonZero && (remW < rxThr) && (rxLvlW >= remW);
  assign txDrain = remNonZero && (remW < txThr) && (txFreeW >= remW);

  assign statRdData = {2'(DEPTH_CODE), FIELD_W'(rxLevel), 2'b00, FIELD_W'(txFree)};
endmodule

// File: rtl/i2c_thresh_fifo.sv
module i2c_thresh_fifo
  import i2cfb_pkg::*;
#(
  parameter int DEPTH_CODE = 1,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [15:0]      cfgWrData,
  output logic [15:0]      cfgRdData,
  output logic [15:0]      statRdData,
  output logic             rxDmaEn,
  output logic             txDmaEn,
  input  logic             cpuTxWr,
  input  logic [7:0]       cpuTxData,
  input  logic             cpuRxRd,
  output logic [7:0]       cpuRxData,
  input  logic             engTxPop,
  output logic [7:0]       engTxData,
  input  logic             engRxPush,
  input  logic [7:0]       engRxData,
  input  logic [CNT_W-1:0] remainCnt,
  output logic             txReady,
  output logic             rxReady,
  output logic             txDrain,
  output logic             rxDrain,
  output logic             txUnderflow,
  output logic             rxOverrun
);
  localparam int DEPTH = 8 << DEPTH_CODE;
  localparam int LVW   = $clog2(DEPTH + 1);

  fifoStrobes_t   strobes;
  logic [LVW-1:0] txLevel;
  logic [LVW-1:0] rxLevel;

  i2cfb_ctrl #(
    .DEPTH_CODE (DEPTH_CODE),
    .DEPTH      (DEPTH),
    .LVW        (LVW),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWrEn     (cfgWrEn),
    .cfgWrData   (cfgWrData),
    .cfgRdData   (cfgRdData),
    .statRdData  (statRdData),
    .rxDmaEn     (rxDmaEn),
    .txDmaEn     (txDmaEn),
    .cpuTxWr     (cpuTxWr),
    .cpuRxRd     (cpuRxRd),
    .engTxPop    (engTxPop),
    .engRxPush   (engRxPush),
    .remainCnt   (remainCnt),
    .txLevel     (txLevel),
    .rxLevel     (rxLevel),
    .strobes     (strobes),
    .txReady     (txReady),
    .rxReady     (rxReady),
    .txDrain     (txDrain),
    .rxDrain     (rxDrain),
    .txUnderflow (txUnderflow),
    .rxOverrun   (rxOverrun)
  );

  i2cfb_datapath #(.DEPTH(DEPTH), .LVW(LVW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cpuTxData (cpuTxData),
    .engRxData (engRxData),
    .engTxData (engTxData),
    .cpuRxData (cpuRxData),
    .txLevel   (txLevel),
    .rxLevel   (rxLevel)
  );
endmodule

// File: rtl/i2cfb_checker.sv
module i2cfb_checker
  import i2cfb_pkg::*;
#(
  parameter int DEPTH_CODE = 1
) (
  input logic                            clk,
  input logic                            rstN,
  input fifoStrobes_t                    strobes,
  input logic [$clog2((8 << DEPTH_CODE) + 1)-1:0] txLevel,
  input logic [$clog2((8 << DEPTH_CODE) + 1)-1:0] rxLevel,
  input logic                            cfgWrEn,
  input logic [15:0]                     cfgWrData,
  input logic                            engRxPush,
  input logic                            engTxPop,
  input logic                            rxOverrun,
  input logic                            txUnderflow
);
  localparam int DEPTH = 8 << DEPTH_CODE;
  localparam int LVW   = $clog2(DEPTH + 1);

  p_rx_level_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rxFlush |=> rxLevel == $past(rxLevel) + LVW'($past(strobes.rxPush)) - LVW'($past(strobes.rxPop)));

  p_tx_level_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.txFlush |=> txLevel == $past(txLevel) + LVW'($past(strobes.txPush)) - LVW'($past(strobes.txPop)));

  p_rx_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rxFlush |=> rxLevel == '0);

  p_tx_flush_empties_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txFlush |=> txLevel == '0);

  p_tx_flush_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.txFlush |-> $past(cfgWrEn && cfgWrData[CFG_TX_FLUSH]));

  p_rx_overrun_r9: assert property (@(posedge clk) disable iff (!rstN)
    (engRxPush && rxLevel == LVW'(DEPTH) && !strobes.rxFlush) |=> rxOverrun);

  p_tx_underflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    (engTxPop && txLevel == '0 && !strobes.txFlush) |=> txUnderflow);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rstN)
    (rxLevel <= LVW'(DEPTH)) && (txLevel <= LVW'(DEPTH)));

  p_no_push_full_r11: assert property (@(posedge clk) disable iff (!rstN)
    (txLevel == LVW'(DEPTH)) |-> !strobes.txPush);
endmodule

bind i2c_thresh_fifo i2cfb_checker #(.DEPTH_CODE(DEPTH_CODE)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .strobes     (strobes),
  .txLevel     (txLevel),
  .rxLevel     (rxLevel),
  .cfgWrEn     (cfgWrEn),
  .cfgWrData   (cfgWrData),
  .engRxPush   (engRxPush),
  .engTxPop    (engTxPop),
  .rxOverrun   (rxOverrun),
  .txUnderflow (txUnderflow)
);

// File: tb/tb_i2c_thresh_fifo.sv
`timescale 1ns/1ps
module tb_i2c_thresh_fifo;
  localparam int DEPTH_CODE = 1;
  localparam int DEPTH      = 8 << DEPTH_CODE;
  localparam int CNT_W      = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [15:0] cfgWrData = '0;
  logic [15:0] cfgRdData, statRdData;
  logic rxDmaEn, txDmaEn;
  logic cpuTxWr = 1'b0;
  logic [7:0] cpuTxData = '0;
  logic cpuRxRd = 1'b0;
  logic [7:0] cpuRxData;
  logic engTxPop = 1'b0;
  logic [7:0] engTxData;
  logic engRxPush = 1'b0;
  logic [7:0] engRxData = '0;
  logic [CNT_W-1:0] remainCnt = '0;
  logic txReady, rxReady, txDrain, rxDrain, txUnderflow, rxOverrun;

  always #2.5 clk = ~clk;

  i2c_thresh_fifo #(.DEPTH_CODE(DEPTH_CODE), .CNT_W(CNT_W)) dut (.*);

  // reference model state
  logic [7:0] txQ[$];
  logic [7:0] rxQ[$];
  int  mRxTh, mTxTh, txN, rxN;
  bit  mRxDma, mTxDma, mRxFl, mTxFl, mOvr, mUdf;
  int  tests = 0, fails = 0;
  bit  done = 1'b0;

  always @(posedge clk) begin
    if (!rstN) begin
      txQ.delete(); rxQ.delete();
      mRxTh = 0; mTxTh = 0; mRxDma = 0; mTxDma = 0;
      mRxFl = 0; mTxFl = 0; mOvr = 0; mUdf = 0;
    end else begin
      txN = txQ.size(); rxN = rxQ.size();
      mOvr = 0; mUdf = 0;
      if (mTxFl) txQ.delete();
      else begin
        if (engTxPop) begin
          if (txN > 0) void'(txQ.pop_front()); else mUdf = 1;
        end
        if (cpuTxWr && txN < DEPTH) txQ.push_back(cpuTxData);
      end
      if (mRxFl) rxQ.delete();
      else begin
        if (cpuRxRd && rxN > 0) void'(rxQ.pop_front());
        if (engRxPush) begin
          if (rxN < DEPTH) rxQ.push_back(engRxData); else mOvr = 1;
        end
      end
      if (cfgWrEn) begin
        mRxDma = cfgWrData[15]; mRxFl = cfgWrData[14]; mRxTh = int'(cfgWrData[13:8]);
        mTxDma = cfgWrData[7];  mTxFl = cfgWrData[6];  mTxTh = int'(cfgWrData[5:0]);
      end else begin
        mRxFl = 0; mTxFl = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int rl, fr, rem, expStat, expCfg;
    rl  = rxQ.size();
    fr  = DEPTH - txQ.size();
    rem = int'(remainCnt);
    expStat = (DEPTH_CODE << 14) | (rl << 8) | fr;
    expCfg  = (int'(mRxDma) << 15) | (mRxTh << 8) | (int'(mTxDma) << 7) | mTxTh;
    chk(int'(statRdData) == expStat, "R3 status", int'(statRdData), expStat);
    chk(int'(cfgRdData) == expCfg, "R1 config readback", int'(cfgRdData), expCfg);
    chk(rxDmaEn == mRxDma && txDmaEn == mTxDma, "R1 dma enables",
        {rxDmaEn, txDmaEn}, {mRxDma, mTxDma});
    chk(rxReady == (rl >= mRxTh + 1), "R4 rxReady", rxReady, rl >= mRxTh + 1);
    chk(txReady == (fr >= mTxTh + 1), "R5 txReady", txReady, fr >= mTxTh + 1);
    chk(rxDrain == (rem > 0 && rem < mRxTh + 1 && rl >= rem), "R6 rxDrain",
        rxDrain, rem > 0 && rem < mRxTh + 1 && rl >= rem);
    chk(txDrain == (rem > 0 && rem < mTxTh + 1 && fr >= rem), "R7 txDrain",
        txDrain, rem > 0 && rem < mTxTh + 1 && fr >= rem);
    chk(rxOverrun == mOvr, "R9 rxOverrun", rxOverrun, mOvr);
    chk(txUnderflow == mUdf, "R10 txUnderflow", txUnderflow, mUdf);
    if (txQ.size() > 0) chk(engTxData == txQ[0], "R2 tx order", engTxData, txQ[0]);
    if (rxQ.size() > 0) chk(cpuRxData == rxQ[0], "R2 rx order", cpuRxData, rxQ[0]);
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
    cfgWrEn = 0; cpuTxWr = 0; cpuRxRd = 0; engTxPop = 0; engRxPush = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++; tests++;
    $display("FAIL watchdog R12 actual=expired expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tick();
    // R12: reset state
    chk(statRdData == 16'h4010, "R12 reset status", int'(statRdData), 16'h4010);
    chk(cfgRdData == 16'h0000, "R12 reset config", int'(cfgRdData), 0);
    chk(!rxReady && txReady && !rxOverrun && !txUnderflow, "R12 reset flags",
        {rxReady, txReady, rxOverrun, txUnderflow}, 4'b0100);

    // R1: config write with flush bits set, thresholds of 4
    cfgWrEn = 1; cfgWrData = 16'hC3C3; tick(); tick();
    chk(cfgRdData == 16'h8383, "R1 flush bits read 0", int'(cfgRdData), 16'h8383);

    // R11, R2: fill transmit past full, then drain past empty (R10)
    for (int i = 0; i < DEPTH + 2; i++) begin cpuTxWr = 1; cpuTxData = 8'(8'h10 + i); tick(); end
    chk(statRdData[5:0] == 6'd0, "R11 tx full room", int'(statRdData[5:0]), 0);
    for (int i = 0; i < DEPTH + 2; i++) begin engTxPop = 1; tick(); end
    // R9: fill receive past full, then read past empty
    for (int i = 0; i < DEPTH + 2; i++) begin engRxPush = 1; engRxData = 8'(8'hA0 + i); tick(); end
    chk(statRdData[13:8] == 6'(DEPTH), "R9 rx stays full", int'(statRdData[13:8]), DEPTH);
    for (int i = 0; i < DEPTH + 2; i++) begin cpuRxRd = 1; tick(); end

    // R6, R7: short final group of 3 with threshold 4
    remainCnt = 3;
    for (int i = 0; i < 4; i++) begin engRxPush = 1; engRxData = 8'(i); tick(); end
    remainCnt = 0;
    // R8: flush receive only while transmit traffic continues
    cpuTxWr = 1; cpuTxData = 8'h55; tick();
    cfgWrEn = 1; cfgWrData = 16'h4303; cpuTxWr = 1; cpuTxData = 8'h66; tick();
    engRxPush = 1; engRxData = 8'h77; tick();
    tick();
    chk(statRdData[13:8] == 6'd0, "R8 rx flushed", int'(statRdData[13:8]), 0);
    chk(int'(statRdData[5:0]) == DEPTH - 2, "R8 tx untouched", int'(statRdData[5:0]), DEPTH - 2);

    // random traffic
    for (int c = 0; c < 6000; c++) begin
      cpuTxWr   = ($urandom_range(0, 99) < 45);
      cpuTxData = 8'($urandom);
      engTxPop  = ($urandom_range(0, 99) < 40);
      engRxPush = ($urandom_range(0, 99) < 45);
      engRxData = 8'($urandom);
      cpuRxRd   = ($urandom_range(0, 99) < 40);
      if ($urandom_range(0, 99) < 3) remainCnt = CNT_W'($urandom_range(0, 20));
      if ($urandom_range(0, 99) < 2) begin
        cfgWrEn = 1;
        cfgWrData = {1'($urandom), 1'($urandom_range(0, 9) == 0), 6'($urandom_range(0, DEPTH + 2)),
                     1'($urandom), 1'($urandom_range(0, 9) == 0), 6'($urandom_range(0, DEPTH + 2))};
      end
      tick();
    end
    finishRun();
  end
endmodule